// File: doc/BRIEF.md
# Per-Line Edge Event Capture with Grouped Interrupt Summary

This block watches a word of input lines that are already synchronous to its clock and records an edge event for every line whose enable bit is set. Each line has its own direction select: a polarity bit of 1 arms it for a low-to-high transition, and 0 arms it for a high-to-low transition. Edges are found by comparing the present level of each line with its level one clock earlier. The comparison uses the true pin level.

Every event sets a bit in a sticky event word that software reads. Events are cleared one byte at a time. A write to a byte keeps the bits written as 1 and clears the bits written as 0, so writing zero clears the whole byte. The event word is summarised into one pending bit per 8-line group, and the pending bits are ORed into a single interrupt request. Bus decoding and pin drivers belong to the surrounding logic.

Top module: `edge_irq_capture`

## Requirements
- R1: With its enable bit 1 and its polarity bit 1, a 0-to-1 transition on a line sets that line's bit in `evt_word`, which is visible after the clock edge where the new level is first sampled. A 1-to-0 transition on that line sets nothing.
- R2: With its enable bit 1 and its polarity bit 0, a 1-to-0 transition on a line sets that line's bit in `evt_word`, and a 0-to-1 transition sets nothing.
- R3: A line whose enable bit is 0 never sets its bit. With all enable bits 0, `evt_word` changes only through clearing writes.
- R4: A set bit in `evt_word` stays set for any number of cycles until a clearing write to its byte.
- R5: A write with `clr_we` = 1 addresses byte `clr_sel` (0 selects bits 7:0, 1 selects bits 15:8, 2 selects bits 23:16). In that byte, each bit written 0 is cleared and each bit written 1 keeps its value. A 1 never sets a bit. Other bytes are unaffected. A `clr_sel` value of 3 has no effect.
- R6: `grp_pend[g]` is 1 exactly when any bit of byte g of `evt_word` is set, so `grp_pend` reads 0 when nothing is latched.
- R7: `irq` is 1 exactly when any bit of `grp_pend` is 1. It stays 1 until every event bit is cleared.
- R8: If a qualifying edge occurs in the same cycle as a clearing write to its byte, the edge wins and its bit ends set.
- R9: Changing a polarity or enable bit while the line is steady creates no event. The previous level keeps following a line while it is disabled, so enabling that line after it has moved creates no event.
- R10: After reset, `evt_word`, `grp_pend` and `irq` are 0. The first cycle after reset records no event, whatever the line levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_lvl | input | 24 | True levels of the monitored lines, synchronous to clk |
| edge_pol | input | 24 | Per-line direction: 1 = rising, 0 = falling |
| line_en | input | 24 | Per-line event enable |
| clr_we | input | 1 | Write strobe for the event word |
| clr_sel | input | 2 | Byte select for the write |
| clr_data | input | 8 | Write data: 0 clears a bit, 1 keeps it |
| evt_word | output | 24 | Sticky event word |
| grp_pend | output | 3 | Per-group pending summary |
| irq | output | 1 | Interrupt request |

## Verification
The bench holds lines high through reset with every line armed for rising edges. A design without a first-cycle guard would latch spurious events on the first cycle after reset. It places an edge on the same cycle as a zero write to its byte. A design that lets the write take priority would lose that event. It moves a line while the line is disabled and then enables it. A design that freezes the previous level while disabled would report a stale edge. It also writes ones, writes to the unused select value, and clears single bytes. This catches a design that sets bits from write data, that decodes the select wrongly, or whose pending summary or IRQ lags the event word.

// File: rtl/edge_irq_pkg.sv
// Package: shared default sizes for the edge capture block.
// Assumes nothing beyond the defaults being used by the top module.
package edge_irq_pkg;
    localparam int unsigned LINES_DEF = 24;  // monitored lines
    localparam int unsigned GRP_W_DEF = 8;   // lines per pending group
endpackage

// File: rtl/edge_irq_detect.sv
// Module: edge_irq_detect
// Finds qualified edges per line by comparing the present level with the
// level one clock earlier. Assumes the levels are already synchronous to clk.
// The first cycle after reset only loads the history and reports nothing.
module edge_irq_detect #(
    parameter int unsigned LINES = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl,
    input  logic [LINES-1:0] pol,
    input  logic [LINES-1:0] en,
    output logic [LINES-1:0] hit
);
    logic [LINES-1:0] prev_q;
    logic             hist_vld_q;

    // Track every line's previous level, enabled or not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= '0;
            hist_vld_q <= 1'b0;
        end else begin
            prev_q     <= lvl;
            hist_vld_q <= 1'b1;
        end
    end

    // Per-line edge qualification by direction and enable.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic rise, fall;
        assign rise   = lvl[i] & ~prev_q[i];
        assign fall   = ~lvl[i] & prev_q[i];
        assign hit[i] = hist_vld_q & en[i] & (pol[i] ? rise : fall);
    end
endmodule

// File: rtl/edge_irq_store.sv
// Module: edge_irq_store
// Sticky event word, one byte-wide group per generate iteration. A write
// ANDs the group with the data. A new hit is ORed in afterwards, so it wins
// over a clear in the same cycle.
module edge_irq_store #(
    parameter int unsigned LINES = 24,
    parameter int unsigned GRP_W = 8,
    localparam int unsigned NGRP = LINES / GRP_W,
    localparam int unsigned SEL_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] hit,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [GRP_W-1:0] wdata,
    output logic [LINES-1:0] word
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic sel_me;
        assign sel_me = we && (sel == SEL_W'(g));

        // Hold, clear by write mask, then merge new hits.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word[g*GRP_W +: GRP_W] <= '0;
            else if (sel_me)
                word[g*GRP_W +: GRP_W] <= (word[g*GRP_W +: GRP_W] & wdata)
                                          | hit[g*GRP_W +: GRP_W];
            else
                word[g*GRP_W +: GRP_W] <= word[g*GRP_W +: GRP_W]
                                          | hit[g*GRP_W +: GRP_W];
        end
    end
endmodule

// File: rtl/edge_irq_summary.sv
// Module: edge_irq_summary
// Reduces the event word to one pending bit per group and one request.
// It is purely combinational from the stored word.
module edge_irq_summary #(
    parameter int unsigned LINES = 24,
    parameter int unsigned GRP_W = 8,
    localparam int unsigned NGRP = LINES / GRP_W
) (
    input  logic [LINES-1:0] word,
    output logic [NGRP-1:0]  pend,
    output logic             req
);
    for (genvar g = 0; g < NGRP; g++) begin : g_or
        assign pend[g] = |word[g*GRP_W +: GRP_W];
    end
    assign req = |pend;
endmodule

// File: rtl/edge_irq_capture.sv
// Module: edge_irq_capture (top)
// Per-line polarity-selectable edge capture into a sticky, byte-clearable
// event word, with a grouped pending summary and one interrupt request.
// Assumes LINES is a multiple of GRP_W and the inputs are synchronous to clk.
module edge_irq_capture
    import edge_irq_pkg::*;
#(
    parameter int unsigned LINES = LINES_DEF,
    parameter int unsigned GRP_W = GRP_W_DEF,
    localparam int unsigned NGRP = LINES / GRP_W,
    localparam int unsigned SEL_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_lvl,
    input  logic [LINES-1:0] edge_pol,
    input  logic [LINES-1:0] line_en,
    input  logic             clr_we,
    input  logic [SEL_W-1:0] clr_sel,
    input  logic [GRP_W-1:0] clr_data,
    output logic [LINES-1:0] evt_word,
    output logic [NGRP-1:0]  grp_pend,
    output logic             irq
);
    logic [LINES-1:0] hit;

    edge_irq_detect #(.LINES(LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .lvl(line_lvl), .pol(edge_pol),
        .en(line_en), .hit(hit)
    );

    edge_irq_store #(.LINES(LINES), .GRP_W(GRP_W)) u_store (
        .clk(clk), .rst_n(rst_n), .hit(hit), .we(clr_we), .sel(clr_sel),
        .wdata(clr_data), .word(evt_word)
    );

    edge_irq_summary #(.LINES(LINES), .GRP_W(GRP_W)) u_summary (
        .word(evt_word), .pend(grp_pend), .req(irq)
    );
endmodule

// File: rtl/edge_irq_capture_chk.sv
// Module: edge_irq_capture_chk
// Port-level checker bound to edge_irq_capture. It keeps its own copy of the
// line history so that it can predict which bits must be set.
module edge_irq_capture_chk #(
    parameter int unsigned LINES = 24,
    parameter int unsigned GRP_W = 8,
    localparam int unsigned NGRP = LINES / GRP_W,
    localparam int unsigned SEL_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] line_lvl,
    input logic [LINES-1:0] edge_pol,
    input logic [LINES-1:0] line_en,
    input logic             clr_we,
    input logic [SEL_W-1:0] clr_sel,
    input logic [GRP_W-1:0] clr_data,
    input logic [LINES-1:0] evt_word,
    input logic [NGRP-1:0]  grp_pend,
    input logic             irq
);
    logic [LINES-1:0] c_prev_q;
    logic             c_vld_q;
    logic [LINES-1:0] keep;
    logic [LINES-1:0] rise_exp;
    logic [LINES-1:0] fall_exp;

    // Independent history of the line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_prev_q <= '0;
            c_vld_q  <= 1'b0;
        end else begin
            c_prev_q <= line_lvl;
            c_vld_q  <= 1'b1;
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_keep
        assign keep[g*GRP_W +: GRP_W] =
            (clr_we && clr_sel == SEL_W'(g)) ? clr_data : {GRP_W{1'b1}};
    end

    assign rise_exp = {LINES{c_vld_q}} & line_en & edge_pol & line_lvl & ~c_prev_q;
    assign fall_exp = {LINES{c_vld_q}} & line_en & ~edge_pol & ~line_lvl & c_prev_q;

    AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_exp != '0) |=> ((evt_word & $past(rise_exp)) == $past(rise_exp))); // R1
    AST_FALL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_exp != '0) |=> ((evt_word & $past(fall_exp)) == $past(fall_exp))); // R2
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en == '0 && !clr_we) |=> (evt_word == $past(evt_word))); // R3
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_word & $past(evt_word & keep)) == $past(evt_word & keep))); // R4
    AST_NO_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en == '0) |=> ((evt_word & ~$past(evt_word)) == '0)); // R5
    AST_PEND_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_pend == '0) == (evt_word == '0)); // R6
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (grp_pend != '0)); // R7
    AST_FIRST_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !c_vld_q |=> (evt_word == '0)); // R10
endmodule

bind edge_irq_capture edge_irq_capture_chk #(.LINES(LINES), .GRP_W(GRP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .edge_pol(edge_pol),
    .line_en(line_en), .clr_we(clr_we), .clr_sel(clr_sel), .clr_data(clr_data),
    .evt_word(evt_word), .grp_pend(grp_pend), .irq(irq)
);

// File: tb/test_edge_irq_capture.sv
// Directed bench for edge_irq_capture. Inputs change on the falling edge and
// outputs are sampled on the falling edge after each rising edge.
module test_edge_irq_capture;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] line_lvl = '0;
    logic [23:0] edge_pol = '0;
    logic [23:0] line_en = '0;
    logic        clr_we = 1'b0;
    logic [1:0]  clr_sel = '0;
    logic [7:0]  clr_data = '0;
    logic [23:0] evt_word;
    logic [2:0]  grp_pend;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    edge_irq_capture i_edge_irq_capture (
        .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .edge_pol(edge_pol),
        .line_en(line_en), .clr_we(clr_we), .clr_sel(clr_sel),
        .clr_data(clr_data), .evt_word(evt_word), .grp_pend(grp_pend), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Advance one clock and land on the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(logic [1:0] sel, logic [7:0] data);
        clr_we = 1'b1; clr_sel = sel; clr_data = data;
        step();
        clr_we = 1'b0;
    endtask

    // Quiet the lines while disabled, then clear every byte.
    task automatic idle_setup();
        line_en = '0; line_lvl = '0;
        step(); step();
        wr_byte(2'd0, 8'h00); wr_byte(2'd1, 8'h00); wr_byte(2'd2, 8'h00);
    endtask

    task automatic t_reset();
        line_lvl = 24'hFFFFFF; edge_pol = 24'hFFFFFF; line_en = 24'hFFFFFF;
        step(); step();
        check("R10 word in reset", 32'(evt_word), 32'h0);
        rst_n = 1'b1;
        step();
        check("R10 first cycle", 32'(evt_word), 32'h0);
        check("R10 pend", 32'(grp_pend), 32'h0);
        check("R10 irq", 32'(irq), 32'h0);
        step();
        check("R10 steady high", 32'(evt_word), 32'h0);
        line_lvl = '0;
        step();
        check("R1 fall ignored on rising line", 32'(evt_word), 32'h0);
    endtask

    task automatic t_rise();
        idle_setup();
        edge_pol = 24'hFFFFFF; line_en = 24'hFFFFFF; step();
        line_lvl[5] = 1'b1; step();
        check("R1 rise bit5", 32'(evt_word), 32'h20);
        check("R6 pend grp0", 32'(grp_pend), 32'h1);
        check("R7 irq set", 32'(irq), 32'h1);
        line_lvl[5] = 1'b0;
        for (int k = 0; k < 5; k++) step();
        check("R4 sticky", 32'(evt_word), 32'h20);
    endtask

    task automatic t_fall();
        idle_setup();
        edge_pol = '0; line_en = 24'hFFFFFF; step();
        line_lvl[17] = 1'b1; step();
        check("R2 rise ignored", 32'(evt_word), 32'h0);
        line_lvl[17] = 1'b0; step();
        check("R2 fall bit17", 32'(evt_word), 32'h20000);
        check("R6 pend grp2", 32'(grp_pend), 32'h4);
    endtask

    task automatic t_disabled();
        idle_setup();
        edge_pol = 24'hFFFFFF; line_en = '0; step();
        line_lvl = 24'h00F0F0; step();
        line_lvl = 24'h0; step();
        check("R3 disabled word", 32'(evt_word), 32'h0);
        check("R3 disabled irq", 32'(irq), 32'h0);
    endtask

    task automatic t_byte_clear();
        idle_setup();
        edge_pol = 24'hFFFFFF; line_en = 24'hFFFFFF; step();
        line_lvl = 24'h101008; step();
        check("R1 three bits", 32'(evt_word), 32'h101008);
        wr_byte(2'd1, 8'h00);
        check("R5 clear byte1", 32'(evt_word), 32'h100008);
        check("R6 pend after clear", 32'(grp_pend), 32'h5);
        wr_byte(2'd0, 8'hFF);
        check("R5 ones keep", 32'(evt_word), 32'h100008);
        wr_byte(2'd3, 8'h00);
        check("R5 select 3 ignored", 32'(evt_word), 32'h100008);
        wr_byte(2'd2, 8'hEF);
        check("R5 partial clear", 32'(evt_word), 32'h000008);
        check("R7 irq held", 32'(irq), 32'h1);
        wr_byte(2'd0, 8'h00);
        check("R7 irq drops", 32'(irq), 32'h0);
        check("R6 pend zero", 32'(grp_pend), 32'h0);
        line_en = '0; line_lvl = '0; step();
        line_en = 24'hFFFFFF; step();
        wr_byte(2'd1, 8'hFF);
        check("R5 ones never set", 32'(evt_word), 32'h0);
    endtask

    task automatic t_collision();
        idle_setup();
        edge_pol = 24'hFFFFFF; line_en = 24'hFFFFFF; step();
        line_lvl[8] = 1'b1; step();
        check("R8 setup", 32'(evt_word), 32'h100);
        line_lvl[9] = 1'b1;
        wr_byte(2'd1, 8'h00);
        check("R8 edge beats clear", 32'(evt_word), 32'h200);
    endtask

    task automatic t_cfg_change();
        idle_setup();
        line_lvl = 24'h0000FF; step();
        edge_pol = 24'hFFFFFF; line_en = 24'hFFFFFF; step();
        edge_pol = '0; step();
        check("R9 polarity flip", 32'(evt_word), 32'h0);
        line_en = '0; step();
        line_en = 24'hFFFFFF; step();
        check("R9 enable toggle", 32'(evt_word), 32'h0);
        line_en = '0; line_lvl = '0; step();
        line_en = 24'hFFFFFF; step();
        check("R9 history tracks while disabled", 32'(evt_word), 32'h0);
    endtask

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_disabled();
        t_byte_clear();
        t_collision();
        t_cfg_change();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule